// File: doc/BRIEF.md
# Maintenance Response Packet Parser

This block takes inbound maintenance response packets one 32-bit word at a time from a cycle/strobe/acknowledge slave bus. The bus address of each word says whether it belongs to a read response or a write response. The block pulls the header fields, the two device IDs, the status, the target transaction ID and the hop count into output registers.

For a read response, the payload arrives as double-words that sit 16 bits out of step with the bus words. The block joins the halves back into aligned 32-bit words and stores them in a 16-entry buffer, which the consumer reads by index. When a complete packet has arrived and the bus cycle has ended, the block raises the ready flag for that response type. It then accepts nothing more until the consumer pulses `done`.

Top module: `mresp_parser`

## Requirements
- R1: After reset, `busAck`, `readRdy` and `writeRdy` are 0, and every header output (`vcOut`, `crfOut`, `prioOut`, `ttOut`, `dstId`, `srcId`, `status`, `tid`, `hop`) is 0.
- R2: While the parser is accepting, a strobed word inside an active cycle is answered by `busAck` high for exactly one cycle. `busAck` is low in the following cycle.
- R3: Words at address 0x82 belong to a read response and words at 0x83 to a write response. A word at any other address is acknowledged, changes no output and never leads to a ready flag.
- R4: Packet word 0 gives `vcOut` from bit 9, `crfOut` from bit 8, `prioOut` from bits 7:6 and `ttOut` from bits 5:4.
- R5: Packet word 1 is loaded into `dstId` and packet word 2 into `srcId`.
- R6: Packet word 3 gives `status` from bits 27:24, `tid` from bits 23:16 and `hop` from bits 15:8. Bits 31:28 (transaction code) and bits 7:0 are not decoded.
- R7: In a read response, buffer entry k equals {word(4+k)[15:0], word(5+k)[31:16]}, for every k in 0..15 whose word 5+k was received.
- R8: A write response is complete after words 0..3. Word 4 and any later words are acknowledged and discarded, and the payload buffer is left unchanged.
- R9: A ready flag rises only in the cycle after `busCyc` falls, and only if the packet was complete: at least 5 words for a read response, at least 4 for a write response. An incomplete packet raises no flag.
- R10: While a ready flag is high, strobes get no acknowledge and the flag stays high. A one-cycle `done` clears the flag, and the next read response writes the buffer again from entry 0.
- R11: Read response words after word 20 are acknowledged but do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busCyc | input | 1 | Bus cycle active; framed around one packet |
| busStb | input | 1 | Word strobe |
| busAdr | input | 8 | Word address; selects the response type |
| busDat | input | 32 | Packet word |
| busAck | output | 1 | Word acknowledge |
| done | input | 1 | Consumer finished with the packet |
| readRdy | output | 1 | Read response held for the consumer |
| writeRdy | output | 1 | Write response held for the consumer |
| vcOut | output | 1 | Virtual channel bit |
| crfOut | output | 1 | Critical request flow bit |
| prioOut | output | 2 | Priority |
| ttOut | output | 2 | Transport type |
| dstId | output | 32 | Destination ID |
| srcId | output | 32 | Source ID |
| status | output | 4 | Response status |
| tid | output | 8 | Target transaction ID |
| hop | output | 8 | Hop count |
| bufIdx | input | 4 | Payload buffer read index |
| bufData | output | 32 | Payload word at `bufIdx` |

## Verification
If the word index is corrupted, the wrong bus word lands in a header field or a buffer entry. That error is visible at the ports as soon as the ready flag rises, when every field and all sixteen entries are read back. A stale buffer write address shows up as payload that is shifted or wrapped, so the bench sends an overlong packet and then a short one. A fault in the control state shows at `busAck` or the ready flags within one cycle, because the bench compares the flags against its model on every clock and checks every acknowledge for its pulse shape.

// File: rtl/mresp_pkg.sv
package mresp_pkg;
  localparam logic [7:0] ADR_READ_RESP  = 8'h82;
  localparam logic [7:0] ADR_WRITE_RESP = 8'h83;

  typedef struct packed {
    logic hdrWe;
    logic dstWe;
    logic srcWe;
    logic infoWe;
    logic saveWe;
    logic bufWe;
    logic clrAddr;
  } dpCtl_t;
endpackage

// File: rtl/mresp_ctrl.sv
module mresp_ctrl
  import mresp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_WORDS = 33
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busCyc,
  input  logic       busStb,
  input  logic [7:0] busAdr,
  input  logic       done,
  output logic       busAck,
  output logic       readRdy,
  output logic       writeRdy,
  output dpCtl_t     ctl
);
  localparam int IDXW = $clog2(MAX_WORDS + 1);
  localparam logic [IDXW-1:0] IDX_SKEW  = IDXW'(4);
  localparam logic [IDXW-1:0] IDX_FIRST = IDXW'(5);
  localparam logic [IDXW-1:0] IDX_LAST  = IDXW'(4 + DEPTH);
  localparam logic [IDXW-1:0] IDX_LIMIT = IDXW'(MAX_WORDS);

  typedef enum logic {ST_RX, ST_HOLD} state_t;

  state_t         state;
  logic [IDXW-1:0] idx;
  logic           rdCmp, wrCmp;
  logic           isRd, isWr, take, hit, inLen;

  assign isRd  = (busAdr == ADR_READ_RESP);
  assign isWr  = (busAdr == ADR_WRITE_RESP);
  assign take  = (state == ST_RX) && busCyc && busStb && !busAck;
  assign hit   = take && (isRd || isWr);
  assign inLen = (idx < IDX_LIMIT);

  always_comb begin
    ctl.hdrWe   = hit && (idx == IDXW'(0));
    ctl.dstWe   = hit && (idx == IDXW'(1));
    ctl.srcWe   = hit && (idx == IDXW'(2));
    ctl.infoWe  = hit && (idx == IDXW'(3));
    ctl.saveWe  = take && isRd && (idx >= IDX_SKEW) && inLen;
    ctl.bufWe   = take && isRd && (idx >= IDX_FIRST) && (idx <= IDX_LAST) && inLen;
    ctl.clrAddr = (state == ST_RX) && !busCyc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_RX;
      idx    <= '0;
      busAck <= 1'b0;
      rdCmp  <= 1'b0;
      wrCmp  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (busCyc) begin
            if (take) begin
              busAck <= 1'b1;
              if (hit && inLen) begin
                idx <= idx + 1'b1;
                if (isRd && idx == IDX_SKEW)    rdCmp <= 1'b1;
                if (isWr && idx == IDXW'(3))    wrCmp <= 1'b1;
              end
            end else begin
              busAck <= 1'b0;
            end
          end else begin
            busAck <= 1'b0;
            idx    <= '0;
            if (rdCmp || wrCmp) state <= ST_HOLD;
          end
        end
        default: begin
          busAck <= 1'b0;
          if (done) begin
            rdCmp <= 1'b0;
            wrCmp <= 1'b0;
            idx   <= '0;
            state <= ST_RX;
          end
        end
      endcase
    end
  end

  assign readRdy  = (state == ST_HOLD) && rdCmp;
  assign writeRdy = (state == ST_HOLD) && wrCmp;

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  a_r2_ack_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busStb && busCyc));
  a_r10_no_ack_ready: assert property (@(posedge clk) disable iff (!rstN)
    (readRdy || writeRdy) |-> !busAck);
  a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((readRdy || writeRdy) && !done) |=> (readRdy || writeRdy));
  a_r9_rise_after_cyc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readRdy || writeRdy) |-> $past(!busCyc));
  a_r3_one_type: assert property (@(posedge clk) disable iff (!rstN)
    !(readRdy && writeRdy));
endmodule

// File: rtl/mresp_dpath.sv
module mresp_dpath
  import mresp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [DATA_W-1:0]        busDat,
  input  logic [$clog2(DEPTH)-1:0] bufIdx,
  output logic                     vcOut,
  output logic                     crfOut,
  output logic [1:0]               prioOut,
  output logic [1:0]               ttOut,
  output logic [DATA_W-1:0]        dstId,
  output logic [DATA_W-1:0]        srcId,
  output logic [3:0]               status,
  output logic [7:0]               tid,
  output logic [7:0]               hop,
  output logic [DATA_W-1:0]        bufData
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   upper;
  logic [AW-1:0]     wrAddr;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcOut   <= 1'b0;
      crfOut  <= 1'b0;
      prioOut <= '0;
      ttOut   <= '0;
      dstId   <= '0;
      srcId   <= '0;
      status  <= '0;
      tid     <= '0;
      hop     <= '0;
      upper   <= '0;
      wrAddr  <= '0;
    end else begin
      if (ctl.hdrWe) begin
        vcOut   <= busDat[9];
        crfOut  <= busDat[8];
        prioOut <= busDat[7:6];
        ttOut   <= busDat[5:4];
      end
      if (ctl.dstWe) dstId <= busDat;
      if (ctl.srcWe) srcId <= busDat;
      if (ctl.infoWe) begin
        status <= busDat[27:24];
        tid    <= busDat[23:16];
        hop    <= busDat[15:8];
      end
      if (ctl.saveWe) upper <= busDat[HALF-1:0];
      if (ctl.clrAddr)    wrAddr <= '0;
      else if (ctl.bufWe) wrAddr <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWe) mem[wrAddr] <= {upper, busDat[DATA_W-1:HALF]};
  end

  assign bufData = mem[bufIdx];

  a_r8_no_buf_on_header: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrWe || ctl.dstWe || ctl.srcWe || ctl.infoWe) |-> !ctl.bufWe);
endmodule

// File: rtl/mresp_parser.sv
module mresp_parser
  import mresp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int MAX_WORDS = 33
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busCyc,
  input  logic                     busStb,
  input  logic [7:0]               busAdr,
  input  logic [DATA_W-1:0]        busDat,
  output logic                     busAck,
  input  logic                     done,
  output logic                     readRdy,
  output logic                     writeRdy,
  output logic                     vcOut,
  output logic                     crfOut,
  output logic [1:0]               prioOut,
  output logic [1:0]               ttOut,
  output logic [DATA_W-1:0]        dstId,
  output logic [DATA_W-1:0]        srcId,
  output logic [3:0]               status,
  output logic [7:0]               tid,
  output logic [7:0]               hop,
  input  logic [$clog2(DEPTH)-1:0] bufIdx,
  output logic [DATA_W-1:0]        bufData
);
  dpCtl_t ctl;

  mresp_ctrl #(.DEPTH(DEPTH), .MAX_WORDS(MAX_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busAdr(busAdr),
    .done(done), .busAck(busAck), .readRdy(readRdy), .writeRdy(writeRdy),
    .ctl(ctl)
  );

  mresp_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busDat(busDat), .bufIdx(bufIdx),
    .vcOut(vcOut), .crfOut(crfOut), .prioOut(prioOut), .ttOut(ttOut),
    .dstId(dstId), .srcId(srcId), .status(status), .tid(tid), .hop(hop),
    .bufData(bufData)
  );
endmodule

// File: tb/mresp_parser_tb_top.sv
`timescale 1ns/1ps
module mresp_parser_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCyc = 1'b0, busStb = 1'b0, done = 1'b0;
  logic [7:0]  busAdr = '0;
  logic [31:0] busDat = '0;
  logic [3:0]  bufIdx = '0;
  logic        busAck, readRdy, writeRdy, vcOut, crfOut;
  logic [1:0]  prioOut, ttOut;
  logic [31:0] dstId, srcId, bufData;
  logic [3:0]  status;
  logic [7:0]  tid, hop;

  int errs = 0, checks = 0;
  bit expRd = 0, expWr = 0, cmpOn = 0;
  bit [31:0] pw [0:39];
  bit [31:0] expBuf [0:15];
  bit [31:0] hdrW [0:3];

  always #5 clk = ~clk;

  mresp_parser dut_i (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busAdr(busAdr),
    .busDat(busDat), .busAck(busAck), .done(done), .readRdy(readRdy),
    .writeRdy(writeRdy), .vcOut(vcOut), .crfOut(crfOut), .prioOut(prioOut),
    .ttOut(ttOut), .dstId(dstId), .srcId(srcId), .status(status), .tid(tid),
    .hop(hop), .bufIdx(bufIdx), .bufData(bufData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // ready flags compared against the model on every clock (R9, R10)
  always @(negedge clk) if (cmpOn) begin
    chk(readRdy == expRd, "R9 readRdy", {31'b0, readRdy}, {31'b0, expRd});
    chk(writeRdy == expWr, "R9 writeRdy", {31'b0, writeRdy}, {31'b0, expWr});
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  task automatic build(input bit [31:0] seed, input bit isRead, input int n);
    for (int i = 0; i < n; i++) pw[i] = (32'h9E3779B9 * (i + 1)) ^ seed;
    pw[3][31:28] = isRead ? 4'b0010 : 4'b0011;
  endtask

  task automatic sendWord(input bit [7:0] adr, input bit [31:0] dat);
    busStb = 1'b1; busAdr = adr; busDat = dat;
    @(posedge clk); @(negedge clk);
    chk(busAck === 1'b1, "R2 ack high", {31'b0, busAck}, 32'd1);
    busStb = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(busAck === 1'b0, "R2 ack single", {31'b0, busAck}, 32'd0);
  endtask

  // send n words of pw, drop cyc, model the ready flag
  task automatic sendPacket(input bit [7:0] adr, input int n);
    busCyc = 1'b1;
    for (int i = 0; i < n; i++) sendWord(adr, pw[i]);
    busCyc = 1'b0;
    @(posedge clk);
    if (adr == 8'h82 && n >= 5) expRd = 1;
    if (adr == 8'h83 && n >= 4) expWr = 1;
    if ((adr == 8'h82 || adr == 8'h83) && n >= 4)
      for (int i = 0; i < 4; i++) hdrW[i] = pw[i];
    if (adr == 8'h82)
      for (int k = 0; k < 16; k++) if (5 + k < n) expBuf[k] = {pw[4+k][15:0], pw[5+k][31:16]};
    @(negedge clk);
  endtask

  task automatic checkFields(input string tag);
    chk({vcOut, crfOut, prioOut, ttOut} == {hdrW[0][9], hdrW[0][8], hdrW[0][7:6], hdrW[0][5:4]},
        {tag, " R4 word0"}, {26'b0, vcOut, crfOut, prioOut, ttOut},
        {26'b0, hdrW[0][9:4]});
    chk(dstId == hdrW[1], {tag, " R5 dstId"}, dstId, hdrW[1]);
    chk(srcId == hdrW[2], {tag, " R5 srcId"}, srcId, hdrW[2]);
    chk({status, tid, hop} == hdrW[3][27:8], {tag, " R6 info"},
        {12'b0, status, tid, hop}, {12'b0, hdrW[3][27:8]});
  endtask

  task automatic checkBuf(input string tag);
    for (int k = 0; k < 16; k++) begin
      bufIdx = 4'(k);
      #1;
      chk(bufData == expBuf[k], {tag, " R7 buffer"}, bufData, expBuf[k]);
    end
  endtask

  task automatic pulseDone();
    done = 1'b1;
    @(posedge clk);
    expRd = 0; expWr = 0;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busAck == 0 && readRdy == 0 && writeRdy == 0, "R1 control outs",
        {29'b0, busAck, readRdy, writeRdy}, 32'd0);
    chk({vcOut, crfOut, prioOut, ttOut, status, tid, hop} == '0, "R1 small fields",
        {6'b0, vcOut, crfOut, prioOut, ttOut, status, tid, hop}, 32'd0);
    chk(dstId == 0 && srcId == 0, "R1 ids", dstId | srcId, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1;

    // overlong read response: R7, R11
    build(32'h1234_5678, 1, 25);
    sendPacket(8'h82, 25);
    checkFields("readA");
    checkBuf("readA R11");
    pulseDone();

    // write response with trailing word: R8
    build(32'hCAFE_0F0F, 0, 5);
    sendPacket(8'h83, 5);
    checkFields("writeB R8");
    checkBuf("writeB R8 unchanged");
    // R10: strobes ignored while held
    busCyc = 1'b1; busStb = 1'b1; busAdr = 8'h82; busDat = 32'hFFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(busAck == 1'b0, "R10 no ack while ready", {31'b0, busAck}, 32'd0);
    end
    busStb = 1'b0; busCyc = 1'b0;
    @(negedge clk);
    checkFields("R10 held fields");
    pulseDone();

    // R3 foreign address: acked, discarded
    build(32'h0BAD_F00D, 1, 6);
    sendPacket(8'h85, 6);
    checkFields("R3 foreign");
    checkBuf("R3 foreign");

    // R9 incomplete read packet raises no flag
    build(32'h5555_AAAA, 1, 4);
    sendPacket(8'h82, 4);
    @(negedge clk);
    chk(readRdy == 0, "R9 incomplete", {31'b0, readRdy}, 32'd0);

    // short read after done: restarts at entry 0 (R10)
    build(32'h7777_1111, 1, 9);
    sendPacket(8'h82, 9);
    checkFields("readC");
    checkBuf("readC R10 restart");
    pulseDone();

    // minimal write response (R8)
    build(32'h2468_ACE0, 0, 4);
    sendPacket(8'h83, 4);
    checkFields("writeD R8");
    pulseDone();

    repeat (2) @(negedge clk);
    cmpOn = 0;
    finishRun();
  end
endmodule